// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller sits behind a coin slot that takes nickels and dimes. It keeps the paid credit in four levels: 0, 5, 10 and 15 cents. When the credit reaches 15 cents it raises a release signal so that one item is dispensed. Credit above 15 cents is absorbed, and no change is returned. The coin sensor delivers one-cycle pulses on `nickel` and `dime`, and at most one of them is high in any cycle. If both are high together the result is undefined.

A build parameter chooses how the release output is formed, and all three choices share the same credit states. In the decoded-state style (Moore) the output follows the current credit. In the transition style (Mealy) the output is high in the very cycle the completing coin is present. In the registered style the release value is worked out from the coin and the credit, then held in a flip-flop. A second parameter stores the credit either as a 2-bit binary code or as one flop per level. The choice of storage does not change the behaviour seen at the ports. A synchronous active-high reset returns the credit to 0 cents.

Top module: `coin_gate_ctrl`

## Requirements
- R1: When `rst` is high at a rising edge, the credit becomes 0 cents. In every style, `release_o` is low in the cycle after that edge until a new coin pushes the credit to 15 cents.
- R2: Each rising edge with `nickel` high adds 5 cents to the credit. Each rising edge with `dime` high adds 10 cents.
- R3: A sum of 15 cents or more saturates to the 15-cent level. Further coins leave the credit there, and `release_o` stays high until reset.
- R4: At an edge with no coin and no reset, the credit does not change.
- R5: In the decoded-state style (STYLE = OUT_MOORE), `release_o` is high exactly while the credit is 15 cents. It first rises in the cycle after the edge that took in the completing coin.
- R6: In the transition style (STYLE = OUT_MEALY), `release_o` is also high during any cycle in which a coin present at the input will complete 15 cents. These cases are a nickel or a dime at 10 cents, and a dime at 5 cents.
- R7: In the transition style, `release_o` is 0 in every cycle in which `rst` is high, whatever the credit or the coin inputs.
- R8: In the registered style (STYLE = OUT_REGD), `release_o` is a flop output that changes only at a clock edge. After an edge it equals whether the credit that edge produced is 15 cents, so its timing matches R5.
- R9: With one-hot credit storage (ONE_HOT = 1), the output sequence is identical to that of binary storage (ONE_HOT = 0) for the same style and stimulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 0 cents |
| nickel | input | 1 | One-cycle pulse for a 5-cent coin |
| dime | input | 1 | One-cycle pulse for a 10-cent coin |
| release_o | output | 1 | Dispense command, formed per STYLE |

## Verification
The bench pays 15 cents in four coin orders: three nickels, nickel then dime, dime then nickel, and two dimes. It checks in which cycle the release first rises for every style. A transition-style design that waited for the edge would miss the early cycle. A decoded-state design that looked at the coin inputs would rise one cycle too soon. Coins inserted at 15 cents test saturation; a design that wrapped the credit would drop the release. The bench also resets while the credit is 15 cents. This exposes a transition-style output that is not forced low during reset, and a flop style that keeps a stale value.

// File: rtl/coin_gate_pkg.sv
package coin_gate_pkg;

    typedef enum logic [1:0] {
        CREDIT_0  = 2'd0,
        CREDIT_5  = 2'd1,
        CREDIT_10 = 2'd2,
        CREDIT_15 = 2'd3
    } credit_e;

    typedef enum logic [1:0] {
        OUT_MOORE = 2'd0,
        OUT_MEALY = 2'd1,
        OUT_REGD  = 2'd2
    } out_style_e;

    localparam int CREDIT_LEVELS = 4;
    localparam int CREDIT_BITS   = $clog2(CREDIT_LEVELS);

endpackage

// File: rtl/coin_credit_step.sv
module coin_credit_step
    import coin_gate_pkg::*;
(
    input  logic [CREDIT_BITS-1:0] level_i,
    input  logic                   nickel_i,
    input  logic                   dime_i,
    output logic [CREDIT_BITS-1:0] level_o
);

    localparam int SUM_W = CREDIT_BITS + 1;
    localparam logic [SUM_W-1:0] TOP = SUM_W'(CREDIT_LEVELS - 1);

    logic [SUM_W-1:0] step_amt;
    logic [SUM_W-1:0] sum;

    always_comb begin
        step_amt = '0;
        if (dime_i) begin
            step_amt = SUM_W'(2);
        end else if (nickel_i) begin
            step_amt = SUM_W'(1);
        end
        sum = {1'b0, level_i} + step_amt;
        if (sum >= TOP) begin
            level_o = TOP[CREDIT_BITS-1:0];
        end else begin
            level_o = sum[CREDIT_BITS-1:0];
        end
    end

endmodule

// File: rtl/coin_credit_store.sv
module coin_credit_store
    import coin_gate_pkg::*;
#(
    parameter bit ONE_HOT = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CREDIT_BITS-1:0] level_d,
    output logic [CREDIT_BITS-1:0] level_q
);

    localparam int SW = ONE_HOT ? CREDIT_LEVELS : CREDIT_BITS;

    typedef struct packed {
        logic [SW-1:0] bits;
    } store_t;

    store_t st_d, st_q;

    generate
        if (ONE_HOT) begin : g_onehot
            always_comb begin
                st_d.bits = '0;
                if (rst) begin
                    st_d.bits[0] = 1'b1;
                end else begin
                    st_d.bits[level_d] = 1'b1;
                end
            end

            always_comb begin
                level_q = '0;
                for (int i = 0; i < CREDIT_LEVELS; i++) begin
                    if (st_q.bits[i]) begin
                        level_q = CREDIT_BITS'(i);
                    end
                end
            end
        end else begin : g_binary
            always_comb begin
                st_d.bits = rst ? '0 : level_d;
            end

            always_comb begin
                level_q = st_q.bits;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/coin_release_gen.sv
module coin_release_gen
    import coin_gate_pkg::*;
#(
    parameter out_style_e STYLE = OUT_MOORE
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   nickel,
    input  logic                   dime,
    input  logic [CREDIT_BITS-1:0] level_q,
    output logic                   release_o
);

    localparam logic [CREDIT_BITS-1:0] FULL = CREDIT_BITS'(CREDIT_LEVELS - 1);

    generate
        if (STYLE == OUT_MOORE) begin : g_moore
            always_comb begin
                release_o = (level_q == FULL);
            end
        end else if (STYLE == OUT_MEALY) begin : g_mealy
            logic arc_hit;
            always_comb begin
                arc_hit = (level_q == CREDIT_10 && (nickel || dime))
                       || (level_q == CREDIT_5 && dime)
                       || (level_q == FULL);
                release_o = arc_hit && !rst;
            end
        end else begin : g_regd
            typedef struct packed {
                logic rel;
            } rel_t;
            rel_t rel_d, rel_q;
            logic q1, q0;
            always_comb begin
                q1 = level_q[1];
                q0 = level_q[0];
                rel_d.rel = !rst
                    && (q1 || dime || (q0 && nickel))
                    && ((!q0 && nickel) || (q0 && !nickel) || (q1 && nickel) || (q1 && dime));
            end
            always_ff @(posedge clk) begin
                rel_q <= rel_d;
            end
            always_comb begin
                release_o = rel_q.rel;
            end
        end
    endgenerate

endmodule

// File: rtl/coin_gate_ctrl.sv
module coin_gate_ctrl
    import coin_gate_pkg::*;
#(
    parameter out_style_e STYLE   = OUT_MOORE,
    parameter bit         ONE_HOT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic nickel,
    input  logic dime,
    output logic release_o
);

    logic [CREDIT_BITS-1:0] credit_lvl;
    logic [CREDIT_BITS-1:0] credit_nxt;

    coin_credit_step u_step (
        .level_i  (credit_lvl),
        .nickel_i (nickel),
        .dime_i   (dime),
        .level_o  (credit_nxt)
    );

    coin_credit_store #(.ONE_HOT(ONE_HOT)) u_store (
        .clk     (clk),
        .rst     (rst),
        .level_d (credit_nxt),
        .level_q (credit_lvl)
    );

    coin_release_gen #(.STYLE(STYLE)) u_rel (
        .clk       (clk),
        .rst       (rst),
        .nickel    (nickel),
        .dime      (dime),
        .level_q   (credit_lvl),
        .release_o (release_o)
    );

endmodule

// File: rtl/coin_gate_chk.sv
module coin_gate_chk
    import coin_gate_pkg::*;
#(
    parameter out_style_e STYLE = OUT_MOORE
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   nickel,
    input logic                   dime,
    input logic                   release_o,
    input logic [CREDIT_BITS-1:0] credit_q
);

    // R1
    reset_to_zero_chk: assert property (@(posedge clk)
        rst |=> credit_q == 2'd0);

    // R2
    nickel_adds_chk: assert property (@(posedge clk) disable iff (rst)
        (nickel && !dime && credit_q == 2'd0) |=> credit_q == 2'd1);

    // R2
    dime_adds_chk: assert property (@(posedge clk) disable iff (rst)
        (dime && !nickel && credit_q == 2'd0) |=> credit_q == 2'd2);

    // R3
    full_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        credit_q == 2'd3 |=> credit_q == 2'd3);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!nickel && !dime) |=> $stable(credit_q));

    generate
        if (STYLE == OUT_MEALY) begin : g_mealy
            // R7
            mealy_reset_low_chk: assert property (@(posedge clk)
                rst |-> !release_o);
            // R6
            mealy_early_chk: assert property (@(posedge clk) disable iff (rst)
                (credit_q == 2'd2 && (nickel || dime)) |-> release_o);
            // R6
            mealy_dime_at_five_chk: assert property (@(posedge clk) disable iff (rst)
                (credit_q == 2'd1 && dime) |-> release_o);
        end else begin : g_state_out
            // R5 R8
            full_means_release_chk: assert property (@(posedge clk) disable iff (rst)
                credit_q == 2'd3 |-> release_o);
            // R5 R8
            release_means_full_chk: assert property (@(posedge clk) disable iff (rst)
                release_o |-> credit_q == 2'd3);
        end
    endgenerate

endmodule

bind coin_gate_ctrl coin_gate_chk #(.STYLE(STYLE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .nickel    (nickel),
    .dime      (dime),
    .release_o (release_o),
    .credit_q  (credit_lvl)
);

// File: tb/coin_gate_ctrl_bench.sv
module coin_gate_ctrl_bench;
    import coin_gate_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel = 1'b0;
    logic dime = 1'b0;
    logic rel_moore, rel_mealy, rel_regd, rel_oh, rel_oh_mealy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    coin_gate_ctrl #(.STYLE(OUT_MOORE), .ONE_HOT(1'b0)) u_coin_gate_ctrl (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .release_o(rel_moore));
    coin_gate_ctrl #(.STYLE(OUT_MEALY), .ONE_HOT(1'b0)) u_coin_gate_ctrl_mealy (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .release_o(rel_mealy));
    coin_gate_ctrl #(.STYLE(OUT_REGD), .ONE_HOT(1'b0)) u_coin_gate_ctrl_regd (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .release_o(rel_regd));
    coin_gate_ctrl #(.STYLE(OUT_MOORE), .ONE_HOT(1'b1)) u_coin_gate_ctrl_oh (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .release_o(rel_oh));
    coin_gate_ctrl #(.STYLE(OUT_MEALY), .ONE_HOT(1'b1)) u_coin_gate_ctrl_oh_mealy (
        .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .release_o(rel_oh_mealy));

    typedef struct {
        bit    chk;
        bit    exp_state;
        bit    exp_arc;
        string tag;
    } item_t;

    item_t sb_q[$];
    int model_cr = 0;

    task automatic compare(input string tag, input string who, input logic got, input bit exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s [%s] got %b expected %b at %0t", tag, who, got, exp, $time);
        end
    endtask

    // Drives one cycle of stimulus and pushes the expected outputs for that cycle.
    task automatic step(input bit r, input bit n, input bit d, input bit chk, input string tag);
        item_t it;
        int val;
        @(negedge clk);
        rst = r;
        nickel = n;
        dime = d;
        val = (n ? 5 : 0) + (d ? 10 : 0);
        it.chk = chk;
        it.tag = tag;
        it.exp_state = (model_cr == 15);
        it.exp_arc = !r && ((model_cr == 15) || (model_cr + val >= 15));
        sb_q.push_back(it);
        if (r) model_cr = 0;
        else model_cr = (model_cr + val >= 15) ? 15 : model_cr + val;
    endtask

    task automatic idle(input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) step(1'b0, 1'b0, 1'b0, 1'b1, tag);
    endtask

    task automatic do_reset(input string tag);
        step(1'b1, 1'b0, 1'b0, 1'b1, tag);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(negedge clk);
            #3;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                if (it.chk) begin
                    compare({it.tag, " R5"}, "moore", rel_moore, it.exp_state);
                    compare({it.tag, " R6"}, "mealy", rel_mealy, it.exp_arc);
                    compare({it.tag, " R8"}, "registered", rel_regd, it.exp_state);
                    compare({it.tag, " R9"}, "onehot-moore", rel_oh, it.exp_state);
                    compare({it.tag, " R9"}, "onehot-mealy", rel_oh_mealy, it.exp_arc);
                end
            end
        end
    end

    initial begin : driver
        step(1'b1, 1'b0, 1'b0, 1'b0, "power-up");
        do_reset("R1 reset");
        idle(2, "R1 after reset");

        // nickel, nickel, nickel with gaps
        step(1'b0, 1'b1, 1'b0, 1'b1, "R2 N1");
        idle(1, "R4 hold 5");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R2 N2");
        idle(2, "R4 hold 10");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6 N3 completes");
        idle(3, "R3 held at 15");
        do_reset("R7 reset from 15");
        idle(1, "R1 after reset");

        // nickel then dime, back to back
        step(1'b0, 1'b1, 1'b0, 1'b1, "R2 N of N-D");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R6 D completes N-D");
        idle(2, "R5 N-D full");
        do_reset("R1 reset");

        // dime then nickel
        step(1'b0, 1'b0, 1'b1, 1'b1, "R2 D of D-N");
        idle(1, "R4 hold 10");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R6 N completes D-N");
        idle(1, "R5 D-N full");
        do_reset("R1 reset");

        // dime then dime: 20 cents saturates
        step(1'b0, 1'b0, 1'b1, 1'b1, "R2 D1 of D-D");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R3 D2 overpays");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R3 nickel at 15");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R3 dime at 15");
        idle(2, "R3 held at 15");

        // reset held with coins present
        step(1'b1, 1'b0, 1'b1, 1'b1, "R7 reset with dime");
        step(1'b1, 1'b1, 1'b0, 1'b1, "R7 reset with nickel");
        idle(3, "R1 no coins after reset");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R2 N after reset");
        step(1'b0, 1'b1, 1'b0, 1'b1, "R2 N after reset");
        idle(2, "R4 hold 10 no release");
        step(1'b0, 1'b0, 1'b1, 1'b1, "R6 D at 10");
        idle(2, "R3 held at 15");
        do_reset("R1 final reset");
        idle(2, "R1 final idle");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin : finisher
        fork
            wait (done);
            begin
                #200000;
                checks++;
                errors++;
                $display("FAIL watchdog expired: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule